// File: doc/BRIEF.md
# Context Stack Pointer Sequencer

This block owns the pointer word of a processor context-save stack and moves a fixed-size context (28 words by default) between the stack and an external register file, one word at a time, through a simple synchronous memory port with a ready handshake. The pointer word holds a top-of-stack address, a space counter, a word counter and two sticky overflow flags. While the block is idle, a privileged direct-write port replaces the whole pointer word.

A push always runs. It stores context words 0 up to 27 at rising addresses, and for each word it advances the address, adds one to the word counter and takes one from the space counter. A pull first checks the word counter. If the count is zero, the block asks for the default status words to be loaded from real locations 2 and 3. If the count is between 1 and 27, the block raises an instruction-exception trap. If the count is 28 or more, the block reads the words back in reverse order and steps the address and counters the other way. Overflow in either counter sets a sticky flag and the transfer goes on. Each command ends with one single-cycle pulse: done, trap or default-load.

Top module: `ctxstk_seq`

## Requirements
- R1: After a synchronous reset the pointer word is all zero, `busy_o`, `mem_req_o`, `done_o`, `trap_o` and `dflt_o` are low, and `trap_vec_o` is zero.
- R2: The pointer word is packed with the word count at bits [CNT_W-1:0], the word-overflow flag at bit CNT_W, the space count at [2*CNT_W:CNT_W+1], the space-overflow flag at 2*CNT_W+1 and the top address above them. When idle, `wr_en_i` loads `wr_ptr_i` into it on the next edge. A write while busy is ignored. A command in the same cycle as an idle write is dropped.
- R3: A push stores context words in index order 0 to 27. Each word goes to address top+1, and then the top address rises by one, the word count rises by one and the space count falls by one, all modulo their widths.
- R4: When the word count wraps from its maximum during a push, the word-overflow flag is set and the push still completes with a done pulse.
- R5: A pull with a starting word count of 28 or more reads each word from the current top address, delivers it on the register-file port at indices 27 down to 0, and then lowers the top address by one, lowers the word count by one and raises the space count by one.
- R6: When the space count wraps from its maximum during a pull, the space-overflow flag is set and the pull still completes.
- R7: Both overflow flags stay set through later counting in either direction, and only a direct write can clear them.
- R8: A pull with a starting word count of zero raises `dflt_o` for one cycle, one cycle after the command. It makes no memory access and leaves the pointer word unchanged.
- R9: A pull with a starting word count from 1 to 27 raises `trap_o` for one cycle, one cycle after the command, with `trap_vec_o` = 0x4D. This pulse also stands for the setting of condition-code bit 2. The pointer word stays unchanged.
- R10: A word completes only in a cycle with `mem_rdy_i` high. While it is low, the address, the index and the pointer word hold.
- R11: `done_o` pulses for one cycle in the first cycle with `busy_o` low after a transfer. A command that arrives while busy is ignored. At most one of done, trap and default-load is high at a time.
- R12: A push followed by a pull returns every context word to the register-file index it came from and restores the top address and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Privileged direct write of the pointer word |
| wr_ptr_i | input | PTR_W | Pointer word to load |
| cmd_valid_i | input | 1 | Start a command |
| cmd_pull_i | input | 1 | Command kind: 0 push, 1 pull |
| ptr_o | output | PTR_W | Current pointer word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished pulse |
| trap_o | output | 1 | Instruction-exception trap pulse (also sets condition-code bit 2) |
| trap_vec_o | output | 8 | Trap vector, 0x4D while `trap_o` is high |
| dflt_o | output | 1 | Request to load default status words from locations 2 and 3 |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (push) when high, read when low |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Word to store |
| mem_rdata_i | input | DATA_W | Word read, valid with `mem_rdy_i` |
| mem_rdy_i | input | 1 | Memory completes the current word |
| ctx_idx_o | output | IDX_W | Register-file index of the current word |
| ctx_wdata_i | input | DATA_W | Register-file word at `ctx_idx_o` |
| ctx_we_o | output | 1 | Register-file write strobe (pull) |
| ctx_rdata_o | output | DATA_W | Word to write into the register file |

## Verification
The bench builds the block with ADDR_W = 8, CNT_W = 6 and DATA_W = 16, so the pointer word is 22 bits wide. With a 6-bit count, a single 28-word push from a count of 50 wraps the word counter, and a single pull from a space count of 50 wraps the space counter. Both overflow cases and the sticky behaviour therefore take only a few commands. With a 256-word address space, a push that starts at 0xF0 crosses the address wrap. Ready stalls with a pseudo-random pattern and a long forced stall test the hold behaviour in the middle of a transfer.

// File: rtl/ctxstk_pkg.sv
package ctxstk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_PULL = 2'd2
  } ctl_st_e;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_PUSH = 2'd2,
    PTR_PULL = 2'd3
  } ptr_op_e;

endpackage

// File: rtl/ctxstk_ptr.sv
module ctxstk_ptr
  import ctxstk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 15,
  localparam int PTR_W = 2 * CNT_W + 2 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_op_e           op_i,
  input  logic [PTR_W-1:0]  ld_i,
  output logic [ADDR_W-1:0] top_o,
  output logic [CNT_W-1:0]  wc_o,
  output logic [PTR_W-1:0]  ptr_o
);

  localparam int WOVF_BIT = CNT_W;
  localparam int SC_LSB   = CNT_W + 1;
  localparam int SOVF_BIT = 2 * CNT_W + 1;
  localparam int TOP_LSB  = 2 * CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ADDR_W-1:0] top_q;
  logic [CNT_W-1:0]  wc_q;
  logic [CNT_W-1:0]  sc_q;
  logic              wovf_q;
  logic              sovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q  <= '0;
      wc_q   <= '0;
      sc_q   <= '0;
      wovf_q <= 1'b0;
      sovf_q <= 1'b0;
    end else begin
      unique case (op_i)
        PTR_LOAD: begin
          top_q  <= ld_i[TOP_LSB +: ADDR_W];
          sovf_q <= ld_i[SOVF_BIT];
          sc_q   <= ld_i[SC_LSB +: CNT_W];
          wovf_q <= ld_i[WOVF_BIT];
          wc_q   <= ld_i[CNT_W-1:0];
        end
        PTR_PUSH: begin
          top_q <= top_q + ADDR_W'(1);
          wc_q  <= wc_q + CNT_W'(1);
          sc_q  <= sc_q - CNT_W'(1);
          if (wc_q == CNT_MAX) wovf_q <= 1'b1;
        end
        PTR_PULL: begin
          top_q <= top_q - ADDR_W'(1);
          wc_q  <= wc_q - CNT_W'(1);
          sc_q  <= sc_q + CNT_W'(1);
          if (sc_q == CNT_MAX) sovf_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign top_o = top_q;
  assign wc_o  = wc_q;
  assign ptr_o = {top_q, sovf_q, sc_q, wovf_q, wc_q};

endmodule

// File: rtl/ctxstk_ctl.sv
module ctxstk_ctl
  import ctxstk_pkg::*;
#(
  parameter int         CTX_WORDS = 28,
  parameter int         CNT_W     = 15,
  parameter logic [7:0] TRAP_VEC  = 8'h4D,
  localparam int        IDX_W     = $clog2(CTX_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_pull_i,
  input  logic             mem_rdy_i,
  input  logic [CNT_W-1:0] wc_i,
  output ptr_op_e          op_o,
  output logic             busy_o,
  output logic             pull_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             trap_o,
  output logic             dflt_o,
  output logic [7:0]       trap_vec_o
);

  localparam logic [CNT_W-1:0] CTX_CNT  = CNT_W'(CTX_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CTX_WORDS - 1);

  ctl_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q, trap_q, dflt_q;
  logic [7:0]       vec_q;

  always_comb begin
    unique case (st_q)
      ST_IDLE: op_o = wr_en_i ? PTR_LOAD : PTR_HOLD;
      ST_PUSH: op_o = mem_rdy_i ? PTR_PUSH : PTR_HOLD;
      ST_PULL: op_o = mem_rdy_i ? PTR_PULL : PTR_HOLD;
      default: op_o = PTR_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
      dflt_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      dflt_q <= 1'b0;
      vec_q  <= '0;
      unique case (st_q)
        ST_IDLE: begin
          if (!wr_en_i && cmd_valid_i) begin
            idx_q <= '0;
            if (!cmd_pull_i) begin
              st_q <= ST_PUSH;
            end else if (wc_i == '0) begin
              dflt_q <= 1'b1;
            end else if (wc_i < CTX_CNT) begin
              trap_q <= 1'b1;
              vec_q  <= TRAP_VEC;
            end else begin
              st_q <= ST_PULL;
            end
          end
        end
        ST_PUSH, ST_PULL: begin
          if (mem_rdy_i) begin
            if (idx_q == IDX_LAST) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign pull_o     = (st_q == ST_PULL);
  assign idx_o      = idx_q;
  assign done_o     = done_q;
  assign trap_o     = trap_q;
  assign dflt_o     = dflt_q;
  assign trap_vec_o = vec_q;

endmodule

// File: rtl/ctxstk_seq.sv
module ctxstk_seq
  import ctxstk_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         CNT_W     = 15,
  parameter int         DATA_W    = 32,
  parameter int         CTX_WORDS = 28,
  parameter logic [7:0] TRAP_VEC  = 8'h4D,
  localparam int        PTR_W     = 2 * CNT_W + 2 + ADDR_W,
  localparam int        IDX_W     = $clog2(CTX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_pull_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [7:0]        trap_vec_o,
  output logic              dflt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic [IDX_W-1:0]  ctx_idx_o,
  input  logic [DATA_W-1:0] ctx_wdata_i,
  output logic              ctx_we_o,
  output logic [DATA_W-1:0] ctx_rdata_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CTX_WORDS - 1);

  ptr_op_e           op;
  logic [ADDR_W-1:0] top;
  logic [CNT_W-1:0]  wc;
  logic              pull;
  logic [IDX_W-1:0]  idx;

  ctxstk_ptr #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) ptr_u (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op),
    .ld_i  (wr_ptr_i),
    .top_o (top),
    .wc_o  (wc),
    .ptr_o (ptr_o)
  );

  ctxstk_ctl #(
    .CTX_WORDS (CTX_WORDS),
    .CNT_W     (CNT_W),
    .TRAP_VEC  (TRAP_VEC)
  ) ctl_u (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_pull_i  (cmd_pull_i),
    .mem_rdy_i   (mem_rdy_i),
    .wc_i        (wc),
    .op_o        (op),
    .busy_o      (busy_o),
    .pull_o      (pull),
    .idx_o       (idx),
    .done_o      (done_o),
    .trap_o      (trap_o),
    .dflt_o      (dflt_o),
    .trap_vec_o  (trap_vec_o)
  );

  // push pre-increments onto the next free word, pull reads the occupied top
  assign mem_req_o   = busy_o;
  assign mem_we_o    = busy_o && !pull;
  assign mem_addr_o  = pull ? top : top + ADDR_W'(1);
  assign mem_wdata_o = ctx_wdata_i;
  assign ctx_idx_o   = pull ? IDX_LAST - idx : idx;
  assign ctx_we_o    = pull && mem_rdy_i;
  assign ctx_rdata_o = mem_rdata_i;

endmodule

// File: rtl/ctxstk_chk.sv
module ctxstk_chk #(
  parameter int         CNT_W    = 15,
  parameter int         PTR_W    = 64,
  parameter logic [7:0] TRAP_VEC = 8'h4D
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_i,
  input logic             mem_rdy_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             trap_o,
  input logic             dflt_o,
  input logic [7:0]       trap_vec_o,
  input logic [PTR_W-1:0] ptr_o
);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, trap_o, dflt_o}));

  // R9
  trap_vec_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (trap_vec_o == TRAP_VEC));

  // R9
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $stable(ptr_o));

  // R8
  dflt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dflt_o |-> ($stable(ptr_o) && !busy_o));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !mem_rdy_i) |=> $stable(ptr_o));

  // R7
  wovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && ptr_o[CNT_W]) |=> ptr_o[CNT_W]);

  // R7
  sovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && ptr_o[2*CNT_W+1]) |=> ptr_o[2*CNT_W+1]);

endmodule

bind ctxstk_seq ctxstk_chk #(
  .CNT_W    (CNT_W),
  .PTR_W    (PTR_W),
  .TRAP_VEC (TRAP_VEC)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .mem_rdy_i  (mem_rdy_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .trap_o     (trap_o),
  .dflt_o     (dflt_o),
  .trap_vec_o (trap_vec_o),
  .ptr_o      (ptr_o)
);

// File: tb/ctxstk_seq_tb_top.sv
`timescale 1ns/1ps
module ctxstk_seq_tb_top;

  localparam int AW = 8;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int NW = 28;
  localparam int PW = 2 * CW + 2 + AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en_i = 1'b0;
  logic [PW-1:0] wr_ptr_i = '0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_pull_i = 1'b0;
  logic [PW-1:0] ptr_o;
  logic          busy_o, done_o, trap_o, dflt_o;
  logic [7:0]    trap_vec_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic          mem_rdy_i = 1'b1;
  logic [4:0]    ctx_idx_o;
  logic [DW-1:0] ctx_wdata_i;
  logic          ctx_we_o;
  logic [DW-1:0] ctx_rdata_o;

  always #4 clk = ~clk;

  ctxstk_seq #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .CTX_WORDS(NW)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_ptr_i(wr_ptr_i),
    .cmd_valid_i(cmd_valid_i), .cmd_pull_i(cmd_pull_i), .ptr_o(ptr_o),
    .busy_o(busy_o), .done_o(done_o), .trap_o(trap_o), .trap_vec_o(trap_vec_o),
    .dflt_o(dflt_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_rdy_i(mem_rdy_i), .ctx_idx_o(ctx_idx_o), .ctx_wdata_i(ctx_wdata_i),
    .ctx_we_o(ctx_we_o), .ctx_rdata_o(ctx_rdata_o));

  // environment: stack memory and register file
  logic [DW-1:0] mem [256];
  logic [DW-1:0] regs [32];
  logic [DW-1:0] pulled [32];
  assign mem_rdata_i = mem[mem_addr_o];
  assign ctx_wdata_i = regs[ctx_idx_o];

  always @(posedge clk) begin
    if (mem_req_o && mem_we_o && mem_rdy_i) mem[mem_addr_o] <= mem_wdata_o;
    if (ctx_we_o) pulled[ctx_idx_o] <= ctx_rdata_o;
  end

  int rdy_mode = 0;
  always @(negedge clk) begin
    case (rdy_mode)
      1:       mem_rdy_i <= (($urandom % 4) != 0);
      2:       mem_rdy_i <= 1'b0;
      default: mem_rdy_i <= 1'b1;
    endcase
  end

  int checks = 0;
  int errors = 0;
  bit fin = 0;
  string cur_req = "R1";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!fin) begin
      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference model, updated on every edge
  logic [AW-1:0] m_top;
  logic [CW-1:0] m_wc, m_sc;
  bit m_wovf, m_sovf, m_done, m_trap, m_dflt;
  int m_st, m_idx;

  function automatic logic [PW-1:0] pk(int top, int sc, bit sovf, int wc, bit wovf);
    logic [AW-1:0] t = AW'(top);
    logic [CW-1:0] s = CW'(sc);
    logic [CW-1:0] w = CW'(wc);
    return {t, sovf, s, wovf, w};
  endfunction

  always @(posedge clk) begin
    m_done = 0; m_trap = 0; m_dflt = 0;
    if (rst) begin
      m_top = '0; m_wc = '0; m_sc = '0; m_wovf = 0; m_sovf = 0; m_st = 0; m_idx = 0;
    end else if (m_st == 0) begin
      if (wr_en_i) begin
        m_wc = wr_ptr_i[CW-1:0]; m_wovf = wr_ptr_i[CW];
        m_sc = wr_ptr_i[2*CW:CW+1]; m_sovf = wr_ptr_i[2*CW+1];
        m_top = wr_ptr_i[PW-1:2*CW+2];
      end else if (cmd_valid_i) begin
        m_idx = 0;
        if (!cmd_pull_i) m_st = 1;
        else if (m_wc == 0) m_dflt = 1;
        else if (m_wc < NW) m_trap = 1;
        else m_st = 2;
      end
    end else if (mem_rdy_i) begin
      if (m_st == 1) begin
        if (m_wc == '1) m_wovf = 1;
        m_wc = m_wc + 1'b1; m_sc = m_sc - 1'b1; m_top = m_top + 1'b1;
      end else begin
        if (m_sc == '1) m_sovf = 1;
        m_sc = m_sc + 1'b1; m_wc = m_wc - 1'b1; m_top = m_top - 1'b1;
      end
      m_idx++;
      if (m_idx == NW) begin m_st = 0; m_done = 1; end
    end
  end

  int n_done = 0, n_trap = 0, n_dflt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      check(ptr_o == {m_top, m_sovf, m_sc, m_wovf, m_wc}, cur_req, "ptr_o", ptr_o,
            {m_top, m_sovf, m_sc, m_wovf, m_wc});
      check(busy_o == (m_st != 0), cur_req, "busy_o", busy_o, m_st != 0);
      check(done_o == m_done, cur_req, "done_o", done_o, m_done);
      check(trap_o == m_trap, cur_req, "trap_o", trap_o, m_trap);
      check(dflt_o == m_dflt, cur_req, "dflt_o", dflt_o, m_dflt);
      check(trap_vec_o == (m_trap ? 8'h4D : 8'h00), cur_req, "trap_vec_o", trap_vec_o,
            m_trap ? 8'h4D : 8'h00);
      check(mem_req_o == (m_st != 0), cur_req, "mem_req_o", mem_req_o, m_st != 0);
      if (m_st != 0) begin
        check(mem_addr_o == ((m_st == 1) ? m_top + 1'b1 : m_top), cur_req, "mem_addr_o",
              mem_addr_o, (m_st == 1) ? m_top + 1'b1 : m_top);
        check(mem_we_o == (m_st == 1), cur_req, "mem_we_o", mem_we_o, m_st == 1);
        check(int'(ctx_idx_o) == ((m_st == 1) ? m_idx : NW - 1 - m_idx), cur_req,
              "ctx_idx_o", ctx_idx_o, (m_st == 1) ? m_idx : NW - 1 - m_idx);
      end
      if (done_o) n_done++;
      if (trap_o) n_trap++;
      if (dflt_o) n_dflt++;
    end
  end

  task automatic wr(int top, int sc, bit sovf, int wc, bit wovf);
    @(negedge clk); wr_en_i = 1'b1; wr_ptr_i = pk(top, sc, sovf, wc, wovf);
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic cmd(bit pull);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_pull_i = pull;
    @(negedge clk); cmd_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int d0, t0, f0;
    for (int i = 0; i < 32; i++) begin regs[i] = DW'(16'h1000 + i * 16'h0101); pulled[i] = '0; end
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ptr_o == '0, "R1", "ptr after reset", ptr_o, 0);
    check(!busy_o && !mem_req_o && !done_o && !trap_o && !dflt_o, "R1", "idle after reset",
          {busy_o, mem_req_o, done_o, trap_o, dflt_o}, 0);

    cur_req = "R2";
    wr(16'h10, 40, 0, 0, 0);
    check(ptr_o == pk(16'h10, 40, 0, 0, 0), "R2", "direct write", ptr_o, pk(16'h10, 40, 0, 0, 0));

    cur_req = "R8"; f0 = n_dflt;
    cmd(1);
    check(n_dflt == f0 + 1, "R8", "default-load pulses", n_dflt, f0 + 1);
    check(ptr_o == pk(16'h10, 40, 0, 0, 0), "R8", "ptr unchanged", ptr_o, pk(16'h10, 40, 0, 0, 0));

    cur_req = "R3"; rdy_mode = 1; d0 = n_done;
    cmd(0);
    rdy_mode = 0;
    check(ptr_o == pk(16'h2C, 12, 0, 28, 0), "R3", "after push", ptr_o, pk(16'h2C, 12, 0, 28, 0));
    check(n_done == d0 + 1, "R11", "done pulses", n_done, d0 + 1);
    for (int i = 0; i < NW; i++)
      check(mem[16'h11 + i] == regs[i], "R3", "stored word", mem[16'h11 + i], regs[i]);

    cur_req = "R5"; rdy_mode = 1;
    cmd(1);
    rdy_mode = 0;
    check(ptr_o == pk(16'h10, 40, 0, 0, 0), "R12", "restored ptr", ptr_o, pk(16'h10, 40, 0, 0, 0));
    for (int i = 0; i < NW; i++)
      check(pulled[i] == regs[i], "R12", "round-trip word", pulled[i], regs[i]);

    cur_req = "R9"; t0 = n_trap;
    wr(16'h20, 7, 0, 5, 0);
    cmd(1);
    wr(16'h20, 7, 0, 27, 0);
    cmd(1);
    check(n_trap == t0 + 2, "R9", "trap pulses", n_trap, t0 + 2);
    check(ptr_o == pk(16'h20, 7, 0, 27, 0), "R9", "ptr unchanged", ptr_o, pk(16'h20, 7, 0, 27, 0));

    cur_req = "R4"; d0 = n_done;
    wr(16'hF0, 60, 0, 50, 0);
    cmd(0);
    check(ptr_o == pk(16'h0C, 32, 0, 14, 1), "R4", "word overflow push", ptr_o, pk(16'h0C, 32, 0, 14, 1));
    check(n_done == d0 + 1, "R4", "push completed", n_done, d0 + 1);

    cur_req = "R7";
    cmd(0);
    check(ptr_o == pk(16'h28, 4, 0, 42, 1), "R7", "wovf kept on push", ptr_o, pk(16'h28, 4, 0, 42, 1));
    cmd(1);
    check(ptr_o[CW] == 1'b1, "R7", "wovf kept on pull", ptr_o[CW], 1);

    cur_req = "R6";
    wr(16'h30, 50, 0, 40, 0);
    cmd(1);
    check(ptr_o == pk(16'h14, 14, 1, 12, 0), "R6", "space overflow pull", ptr_o, pk(16'h14, 14, 1, 12, 0));

    cur_req = "R7";
    cmd(0);
    check(ptr_o == pk(16'h30, 50, 1, 40, 0), "R7", "sovf kept on push", ptr_o, pk(16'h30, 50, 1, 40, 0));
    wr(16'h30, 50, 0, 40, 0);
    check(ptr_o == pk(16'h30, 50, 0, 40, 0), "R7", "write clears flag", ptr_o, pk(16'h30, 50, 0, 40, 0));

    cur_req = "R11"; d0 = n_done; t0 = n_trap; f0 = n_dflt;
    wr(16'h40, 10, 0, 0, 0);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_pull_i = 1'b0;
    @(negedge clk); cmd_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    wr_en_i = 1'b1; wr_ptr_i = '1; cmd_valid_i = 1'b1; cmd_pull_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; cmd_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    check(ptr_o == pk(16'h5C, 46, 0, 28, 0), "R2", "write while busy ignored", ptr_o, pk(16'h5C, 46, 0, 28, 0));
    check(n_done == d0 + 1 && n_trap == t0 && n_dflt == f0, "R11", "busy command ignored",
          {n_done - d0, n_trap - t0, n_dflt - f0}, 1);

    cur_req = "R2";
    @(negedge clk); wr_en_i = 1'b1; wr_ptr_i = pk(16'h80, 20, 0, 0, 0);
    cmd_valid_i = 1'b1; cmd_pull_i = 1'b0;
    @(negedge clk); wr_en_i = 1'b0; cmd_valid_i = 1'b0;
    @(negedge clk);
    check(!busy_o && ptr_o == pk(16'h80, 20, 0, 0, 0), "R2", "write beats command",
          {busy_o, ptr_o}, pk(16'h80, 20, 0, 0, 0));

    cur_req = "R10"; rdy_mode = 2;
    @(negedge clk); cmd_valid_i = 1'b1; cmd_pull_i = 1'b0;
    @(negedge clk); cmd_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    check(busy_o && ptr_o == pk(16'h80, 20, 0, 0, 0) && mem_addr_o == 8'h81, "R10",
          "stall holds", {busy_o, ptr_o}, {1'b1, pk(16'h80, 20, 0, 0, 0)});
    rdy_mode = 0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    check(ptr_o == pk(16'h9C, 56, 0, 28, 0), "R10", "after stalled push", ptr_o, pk(16'h9C, 56, 0, 28, 0));

    finish_sim();
  end

endmodule